// File: doc/BRIEF.md
# Differential Pixel Clock Output Controller

This block produces a complementary pair of pixel clock outputs inside a fast synchronous clock domain. Each phase of the pair is advanced by a toggle-enable pulse from the currently active source. The source is either the synthesized clock or the reference clock. A control register bit picks the source, and the block applies a change only at a safe point in the waveform. Out of reset the reference source is active, so the pair toggles before any register has been written.

A second control bit freezes the pair with the positive output high and the negative output low. This lets a downstream video DAC pipeline be cleared. Software writes the bit to 1 and then back to 0. Clearing the bit only arms the release. Toggling restarts on the next pulse of the divided load-clock rising edge, so the restart lines up with the load clock.

Top module: `pixclk_diff_out`

## Requirements
- R1: From reset onward, `clkNeg` is always the inverse of `clkPos`.
- R2: Reset drives `clkPos`=0 and `clkNeg`=1 and makes the reference source active. With `refSelBit`=1 after reset, `refTick` toggles the pair and `synthTick` does not.
- R3: While running with `holdBit`=0, a tick of the active source (reference when active source is 1, synthesized when 0) sampled at a clock edge inverts both outputs at that edge. A tick of the inactive source has no effect.
- R4: A `holdBit` of 1 sampled at an edge makes `clkPos`=1 and `clkNeg`=0 after that edge. The pair keeps these levels whatever the ticks do for as long as the bit stays 1.
- R5: Release happens at the first edge that samples `holdBit`=1 followed by `holdBit`=0. That edge only arms the release, and a `loadEdge` pulse at that same edge is ignored. The pair stays at the hold levels until the first later edge that samples `loadEdge`=1. At that edge `clkPos` falls to 0 and normal toggling resumes.
- R6: If `holdBit` returns to 1 while a release is armed, the arming is cancelled. A later `loadEdge` pulse does not release the pair until `holdBit` has fallen again.
- R7: A new `refSelBit` value (1 = reference, 0 = synthesized) becomes the active source only at a running edge where `clkPos` is 0 and the active source has no tick. Until then the old source keeps driving the pair.
- R8: While running, `loadEdge` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| synthTick | input | 1 | Toggle-enable of the synthesized clock |
| refTick | input | 1 | Toggle-enable of the reference clock |
| loadEdge | input | 1 | One-cycle pulse marking a load-clock rising edge |
| holdBit | input | 1 | Register bit that freezes the pair when 1 |
| refSelBit | input | 1 | Register bit that requests the reference source when 1 |
| clkPos | output | 1 | Positive pixel clock output |
| clkNeg | output | 1 | Negative pixel clock output |

## Verification
The bench counts the cycles from the fall of the hold bit to the first toggle. It puts a load pulse on the same edge as the fall, where it must be ignored, and a later one, where it must release the pair. A design that released at once or one cycle early would show a count that was too short. The bench cancels an armed release by raising the hold bit again, which catches a design that still let the load pulse through. It requests a source change while the output is high and again while a tick is landing, so a design that switched at once would toggle on the wrong source's tick. Long random runs keep checking the complement and hold levels, and an inverted or stuck negative output would fail there.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_ARMED = 2'd2
  } holdState_t;

  typedef struct packed {
    logic forceHigh;
    logic forceLow;
    logic flip;
  } outStrobe_t;
endpackage

// File: rtl/pixclk_ctrl.sv
module pixclk_ctrl
  import pixclk_pkg::*;
#(
  parameter logic RESET_SRC_REF = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       synthTick,
  input  logic       refTick,
  input  logic       loadEdge,
  input  logic       holdBit,
  input  logic       refSelBit,
  input  logic       posLevel,
  output outStrobe_t strobe,
  output logic       srcRef
);
  holdState_t state, nextState;
  logic srcTick;
  logic switchOk;

  assign srcTick = srcRef ? refTick : synthTick;

  always_comb begin
    nextState = state;
    strobe    = '0;
    switchOk  = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (holdBit) begin
          nextState        = ST_HOLD;
          strobe.forceHigh = 1'b1;
        end else begin
          strobe.flip = srcTick;
          switchOk    = !posLevel && !srcTick;
        end
      end
      ST_HOLD: begin
        strobe.forceHigh = 1'b1;
        if (!holdBit) nextState = ST_ARMED;
      end
      ST_ARMED: begin
        if (holdBit) begin
          nextState        = ST_HOLD;
          strobe.forceHigh = 1'b1;
        end else if (loadEdge) begin
          nextState       = ST_RUN;
          strobe.forceLow = 1'b1;
        end
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      srcRef <= RESET_SRC_REF;
    end else begin
      state <= nextState;
      if (switchOk) srcRef <= refSelBit;
    end
  end

  AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> posLevel); // R4
  AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !holdBit && !loadEdge) |=> posLevel); // R5
  AST_RELEASE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !holdBit && loadEdge) |=> !posLevel); // R5
  AST_RUN_IGNORES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !holdBit && !srcTick) |=> $stable(posLevel)); // R8
  AST_SWITCH_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (srcRef != $past(srcRef)) |-> !$past(posLevel)); // R7
endmodule

// File: rtl/pixclk_drive.sv
module pixclk_drive
  import pixclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  outStrobe_t strobe,
  output logic       posQ,
  output logic       negQ
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      posQ <= 1'b0;
      negQ <= 1'b1;
    end else if (strobe.forceHigh) begin
      posQ <= 1'b1;
      negQ <= 1'b0;
    end else if (strobe.forceLow) begin
      posQ <= 1'b0;
      negQ <= 1'b1;
    end else if (strobe.flip) begin
      posQ <= ~posQ;
      negQ <= ~negQ;
    end
  end

  AST_PAIR_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    posQ != negQ); // R1
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.forceHigh, strobe.forceLow, strobe.flip})); // R3
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.forceHigh |=> (posQ && !negQ)); // R4
endmodule

// File: rtl/pixclk_diff_out.sv
module pixclk_diff_out
  import pixclk_pkg::*;
#(
  parameter logic RESET_SRC_REF = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic synthTick,
  input  logic refTick,
  input  logic loadEdge,
  input  logic holdBit,
  input  logic refSelBit,
  output logic clkPos,
  output logic clkNeg
);
  outStrobe_t strobe;
  logic srcRef;

  pixclk_ctrl #(.RESET_SRC_REF(RESET_SRC_REF)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .synthTick (synthTick),
    .refTick   (refTick),
    .loadEdge  (loadEdge),
    .holdBit   (holdBit),
    .refSelBit (refSelBit),
    .posLevel  (clkPos),
    .strobe    (strobe),
    .srcRef    (srcRef)
  );

  pixclk_drive u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .posQ   (clkPos),
    .negQ   (clkNeg)
  );

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    holdBit |=> (clkPos && !clkNeg)); // R4
endmodule

// File: tb/sim_pixclk_diff_out.sv
module sim_pixclk_diff_out;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic synthTick = 1'b0, refTick = 1'b0, loadEdge = 1'b0;
  logic holdBit = 1'b0, refSelBit = 1'b1;
  logic clkPos, clkNeg;
  int checks = 0;
  int fails = 0;

  // reference model state: 0 run, 1 hold, 2 armed
  int   mState = 0;
  logic mPos = 1'b0;
  logic mSel = 1'b1;

  always #10 clk = ~clk;

  pixclk_diff_out u0 (
    .clk(clk), .rst_n(rst_n), .synthTick(synthTick), .refTick(refTick),
    .loadEdge(loadEdge), .holdBit(holdBit), .refSelBit(refSelBit),
    .clkPos(clkPos), .clkNeg(clkNeg)
  );

  function automatic logic activeTick(logic sel, logic s, logic r);
    return sel ? r : s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mState <= 0; mPos <= 1'b0; mSel <= 1'b1;
    end else begin
      case (mState)
        0: if (holdBit) begin
             mState <= 1; mPos <= 1'b1;
           end else begin
             if (activeTick(mSel, synthTick, refTick)) mPos <= ~mPos;
             if (!mPos && !activeTick(mSel, synthTick, refTick)) mSel <= refSelBit;
           end
        1: if (!holdBit) mState <= 2;
        default: if (holdBit) begin
                   mState <= 1;
                 end else if (loadEdge) begin
                   mState <= 0; mPos <= 1'b0;
                 end
      endcase
    end
  end

  task automatic check(bit ok, string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual pos/neg=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle(logic s, logic r, logic ld, logic h, logic sel);
    synthTick = s; refTick = r; loadEdge = ld; holdBit = h; refSelBit = sel;
    @(posedge clk);
    @(negedge clk);
    check(clkPos === mPos && clkNeg === ~mPos,
          (mState == 0) ? "R1/R3" : "R1/R4", {clkPos, clkNeg}, {mPos, ~mPos});
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected done");
    finishRun();
  end

  initial begin
    int lat;
    void'($urandom(32'd1562));
    repeat (3) @(negedge clk);
    check(clkPos === 1'b0 && clkNeg === 1'b1, "R2", {clkPos, clkNeg}, 2'b01);
    rst_n = 1'b1;
    // R2: reference active after reset
    cycle(1, 0, 0, 0, 1);
    check(clkPos === 1'b0, "R2", {clkPos, clkNeg}, 2'b01);
    cycle(0, 1, 0, 0, 1);
    check(clkPos === 1'b1, "R2", {clkPos, clkNeg}, 2'b10);
    // R7: request synthesized while high: still reference driven
    cycle(1, 0, 0, 0, 0);
    check(clkPos === 1'b1, "R7", {clkPos, clkNeg}, 2'b10);
    cycle(0, 1, 0, 0, 0);  // falls, tick present so no switch yet
    check(clkPos === 1'b0, "R3", {clkPos, clkNeg}, 2'b01);
    cycle(0, 1, 0, 0, 0);  // old source still active: rises
    check(clkPos === 1'b1, "R7", {clkPos, clkNeg}, 2'b10);
    cycle(0, 1, 0, 0, 0);
    cycle(0, 0, 0, 0, 0);  // low, no tick: switch now
    cycle(0, 1, 0, 0, 0);
    check(clkPos === 1'b0, "R7", {clkPos, clkNeg}, 2'b01);
    cycle(1, 0, 0, 0, 0);
    check(clkPos === 1'b1, "R7", {clkPos, clkNeg}, 2'b10);
    // R8: load pulse in run
    cycle(0, 0, 1, 0, 0);
    check(clkPos === 1'b1, "R8", {clkPos, clkNeg}, 2'b10);
    // R4: hold with ticks
    cycle(1, 1, 0, 1, 0);
    repeat (6) cycle(1, 1, 1, 1, 0);
    check(clkPos === 1'b1 && clkNeg === 1'b0, "R4", {clkPos, clkNeg}, 2'b10);
    // R5: drop hold with coincident load pulse, real release 5 later
    cycle(1, 0, 1, 0, 0);
    lat = 0;
    for (int i = 1; i <= 12; i++) begin
      cycle(1, 0, (i == 5), 0, 0);
      if (lat == 0 && clkPos === 1'b0) lat = i;
    end
    checks++;
    if (lat != 5) begin
      fails++;
      $display("FAIL R5: actual release latency=%0d expected=5", lat);
    end
    // R6: cancel armed release
    cycle(0, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 0);
    cycle(0, 0, 0, 1, 0);
    cycle(0, 0, 1, 1, 0);
    check(clkPos === 1'b1, "R6", {clkPos, clkNeg}, 2'b10);
    cycle(0, 0, 0, 0, 0);
    cycle(0, 0, 1, 0, 0);
    check(clkPos === 1'b0, "R5", {clkPos, clkNeg}, 2'b01);
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic h;
      h = holdBit;
      if (($urandom % 40) == 0) h = ~h;
      cycle(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0, h,
            (($urandom % 50) == 0) ? ~refSelBit : refSelBit);
    end
    finishRun();
  end
endmodule